// File: doc/BRIEF.md
# Status Word Register with Interrupt Swap

This block keeps the program status word of a processor core: a 64-bit register that carries per-class interrupt enable bits, a supervisor/problem state bit, a two-bit condition code, an addressing-mode bit and an instruction address. The core changes the word in three ways. A full load replaces it and is allowed only in supervisor state. A condition-code update is allowed in either state and touches only the two code bits. A return copies a saved word back into the register.

No command reads the word out to memory. The word leaves the register only when an interrupt is taken. The current value then goes into that class's old-word slot, and the class's preset new word becomes current in the same clock edge. Four classes each own an old slot and a new slot. The new slots are written through a separate configuration port, which also requires supervisor state. Requests are gated by the enable bits of the current word, and the lowest-numbered eligible class wins. An interrupt that coincides with a command drops the command and flags the collision.

The effective instruction address is derived from the addressing-mode bit: 24 address bits in narrow mode and 31 in wide mode.

Top module: `psw_swap_unit`

## Requirements
- R1: After reset the word holds 64'h0800_0000_0000_0000 (supervisor bit 59 set, everything else zero), and irq_taken, priv_fault and cmd_collide are 0.
- R2: With no interrupt taken, cmd_op=1 (full load) in supervisor state copies cmd_word into the word at the next clock edge.
- R3: cmd_op=1 or cmd_op=3 issued in problem state (bit 59 = 0) leaves the word unchanged and raises priv_fault for exactly one cycle.
- R4: cmd_op=2 (code update) writes cmd_cc into bits [58:57] in either state and leaves the other 62 bits unchanged.
- R5: Class k (bits [63:60], class k enabled by bit 60+k) is accepted only when its enable bit is 1. Masked requests leave the word unchanged and do not raise irq_taken.
- R6: Among accepted requests the lowest-numbered class is served, and irq_cls reports it.
- R7: Taking class k stores the current word in old slot k and loads new slot k as the word in the same edge. irq_taken pulses for one cycle.
- R8: cmd_op=3 (return) in supervisor state loads old slot cmd_cls as the word, which restores the interrupted word bit for bit.
- R9: When an interrupt is taken in the same cycle as any nonzero cmd_op, the swap is performed, the command has no effect and cmd_collide pulses for one cycle.
- R10: With bit 56 = 0, eff_addr is the low 24 bits of the instruction address (bits [31:0]) zero-extended. With bit 56 = 1, it is the low 31 bits zero-extended.
- R11: cfg_we writes cfg_word into new slot cfg_cls only in supervisor state. In problem state the slot is unchanged and priv_fault pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 2 | 0 idle, 1 full load, 2 code update, 3 return |
| cmd_word | input | 64 | Word for a full load |
| cmd_cc | input | 2 | Condition code for an update |
| cmd_cls | input | 2 | Old slot selected by a return |
| cfg_we | input | 1 | New-slot write strobe |
| cfg_cls | input | 2 | New slot to write |
| cfg_word | input | 64 | New-slot data |
| irq_req | input | 4 | Interrupt request per class |
| psw_word | output | 64 | Current word |
| irq_mask | output | 4 | Enable bits [63:60] |
| supv | output | 1 | Supervisor state, bit 59 |
| cc | output | 2 | Condition code, bits [58:57] |
| amode | output | 1 | Addressing mode, bit 56 |
| iaddr | output | 32 | Instruction address, bits [31:0] |
| eff_addr | output | 32 | Mode-limited instruction address |
| irq_taken | output | 1 | One-cycle pulse on a swap |
| irq_cls | output | 2 | Class of the latest swap |
| priv_fault | output | 1 | One-cycle pulse on a refused privileged action |
| cmd_collide | output | 1 | One-cycle pulse when a command lost to a swap |

## Verification
An interrupt swap and a command can fall in the same cycle. The bench provokes this by raising an enabled request on the same edge as a code update. It expects the new word of that class to appear with the commanded code absent, and cmd_collide and irq_taken to pulse together. It then returns through the old slot and checks that the saved word still carries the code it had before the dropped update.

// File: rtl/psw_pkg.sv
package psw_pkg;
   typedef enum logic [1:0] {
      OP_IDLE   = 2'd0,
      OP_LOAD   = 2'd1,
      OP_SETCC  = 2'd2,
      OP_RETURN = 2'd3
   } psw_op_e;
endpackage

// File: rtl/psw_irq_arbiter.sv
module psw_irq_arbiter #(
   parameter int NUM_CLASS = 4,
   parameter int CLS_W     = $clog2(NUM_CLASS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_CLASS-1:0] req,
   input  logic [NUM_CLASS-1:0] mask,
   output logic                 take,
   output logic [CLS_W-1:0]     cls,
   output logic [NUM_CLASS-1:0] grant
);
   logic [NUM_CLASS-1:0] elig;

   for (genvar k = 0; k < NUM_CLASS; k++) begin : g_elig
      assign elig[k] = req[k] & mask[k];
   end

   always_comb begin
      grant = '0;
      cls   = '0;
      for (int i = NUM_CLASS - 1; i >= 0; i--) begin
         if (elig[i]) begin
            grant    = '0;
            grant[i] = 1'b1;
            cls      = CLS_W'(i);
         end
      end
   end

   assign take = |grant;

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R6
   AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> ((req & mask & (grant - 1'b1)) == '0)); // R6
   AST_GRANT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> ((grant & mask) != '0)); // R5
endmodule

// File: rtl/psw_slot_bank.sv
module psw_slot_bank #(
   parameter int              NUM_CLASS = 4,
   parameter int              WORD_W    = 64,
   parameter int              CLS_W     = $clog2(NUM_CLASS),
   parameter logic [WORD_W-1:0] NEW_RST = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              save_en,
   input  logic [CLS_W-1:0]  save_cls,
   input  logic [WORD_W-1:0] save_word,
   input  logic              cfg_en,
   input  logic [CLS_W-1:0]  cfg_cls,
   input  logic [WORD_W-1:0] cfg_word,
   input  logic [CLS_W-1:0]  new_sel,
   input  logic [CLS_W-1:0]  old_sel,
   output logic [WORD_W-1:0] new_word,
   output logic [WORD_W-1:0] old_word
);
   logic [WORD_W-1:0] old_arr [NUM_CLASS];
   logic [WORD_W-1:0] new_arr [NUM_CLASS];

   for (genvar k = 0; k < NUM_CLASS; k++) begin : g_slot
      logic [WORD_W-1:0] old_r;
      logic [WORD_W-1:0] new_r;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            old_r <= '0;
            new_r <= NEW_RST;
         end else begin
            if (save_en && (save_cls == CLS_W'(k))) old_r <= save_word;
            if (cfg_en && (cfg_cls == CLS_W'(k)))   new_r <= cfg_word;
         end
      end
      assign old_arr[k] = old_r;
      assign new_arr[k] = new_r;
   end

   assign new_word = new_arr[new_sel];
   assign old_word = old_arr[old_sel];

   AST_OLD_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
      save_en |=> (old_arr[$past(save_cls)] == $past(save_word))); // R7
   AST_NEW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en |=> (new_arr[$past(new_sel)] == $past(new_word))); // R11
endmodule

// File: rtl/psw_addr_gen.sv
module psw_addr_gen #(
   parameter int ADDR_W   = 32,
   parameter int NARROW_W = 24,
   parameter int WIDE_W   = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              amode,
   input  logic [ADDR_W-1:0] iaddr,
   output logic [ADDR_W-1:0] eff
);
   logic [ADDR_W-1:0] narrow_a;
   logic [ADDR_W-1:0] wide_a;

   assign narrow_a = ADDR_W'(iaddr[NARROW_W-1:0]);

   if (WIDE_W >= ADDR_W) begin : g_wide_full
      assign wide_a = iaddr;
   end else begin : g_wide_trim
      assign wide_a = ADDR_W'(iaddr[WIDE_W-1:0]);
   end

   assign eff = amode ? wide_a : narrow_a;

   AST_NARROW_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !amode |-> (eff[ADDR_W-1:NARROW_W] == '0)); // R10
   AST_NARROW_LOW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      !amode |-> (eff[NARROW_W-1:0] == iaddr[NARROW_W-1:0])); // R10
endmodule

// File: rtl/psw_swap_unit.sv
module psw_swap_unit
   import psw_pkg::*;
#(
   parameter int NUM_CLASS = 4,
   parameter int WORD_W    = 64,
   parameter int CC_W      = 2,
   parameter int ADDR_W    = 32,
   parameter int NARROW_W  = 24,
   parameter int WIDE_W    = 31,
   parameter int CLS_W     = $clog2(NUM_CLASS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           cmd_op,
   input  logic [WORD_W-1:0]    cmd_word,
   input  logic [CC_W-1:0]      cmd_cc,
   input  logic [CLS_W-1:0]     cmd_cls,
   input  logic                 cfg_we,
   input  logic [CLS_W-1:0]     cfg_cls,
   input  logic [WORD_W-1:0]    cfg_word,
   input  logic [NUM_CLASS-1:0] irq_req,
   output logic [WORD_W-1:0]    psw_word,
   output logic [NUM_CLASS-1:0] irq_mask,
   output logic                 supv,
   output logic [CC_W-1:0]      cc,
   output logic                 amode,
   output logic [ADDR_W-1:0]    iaddr,
   output logic [ADDR_W-1:0]    eff_addr,
   output logic                 irq_taken,
   output logic [CLS_W-1:0]     irq_cls,
   output logic                 priv_fault,
   output logic                 cmd_collide
);
   localparam int MASK_LSB  = WORD_W - NUM_CLASS;
   localparam int SUPV_BIT  = MASK_LSB - 1;
   localparam int CC_LSB    = SUPV_BIT - CC_W;
   localparam int AMODE_BIT = CC_LSB - 1;
   localparam logic [WORD_W-1:0] PSW_RST  = WORD_W'(1) << SUPV_BIT;
   localparam logic [WORD_W-1:0] CC_FIELD = ((WORD_W'(1) << CC_W) - 1'b1) << CC_LSB;

   if (NUM_CLASS < 2 || (1 << CLS_W) != NUM_CLASS) begin : g_bad_classes
      $error("NUM_CLASS must be a power of two of at least 2");
   end
   if (AMODE_BIT <= ADDR_W) begin : g_bad_layout
      $error("control fields overlap the instruction address");
   end
   if (NARROW_W >= WIDE_W || WIDE_W > ADDR_W) begin : g_bad_modes
      $error("address mode widths out of order");
   end

   logic [WORD_W-1:0]    psw_q, psw_d;
   logic                 fault_q, fault_d;
   logic                 coll_q, coll_d;
   logic                 taken_q;
   logic [CLS_W-1:0]     tcls_q;
   logic                 take;
   logic [CLS_W-1:0]     take_cls;
   logic [NUM_CLASS-1:0] grant;
   logic [WORD_W-1:0]    new_word, old_word;
   logic                 priv, cfg_ok;
   psw_op_e              op;

   assign priv   = psw_q[SUPV_BIT];
   assign op     = psw_op_e'(cmd_op);
   assign cfg_ok = cfg_we & priv;

   psw_irq_arbiter #(.NUM_CLASS(NUM_CLASS), .CLS_W(CLS_W)) arb_i (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (irq_req),
      .mask  (psw_q[WORD_W-1:MASK_LSB]),
      .take  (take),
      .cls   (take_cls),
      .grant (grant)
   );

   psw_slot_bank #(.NUM_CLASS(NUM_CLASS), .WORD_W(WORD_W), .CLS_W(CLS_W),
                   .NEW_RST(PSW_RST)) bank_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .save_en   (take),
      .save_cls  (take_cls),
      .save_word (psw_q),
      .cfg_en    (cfg_ok),
      .cfg_cls   (cfg_cls),
      .cfg_word  (cfg_word),
      .new_sel   (take_cls),
      .old_sel   (cmd_cls),
      .new_word  (new_word),
      .old_word  (old_word)
   );

   always_comb begin
      psw_d   = psw_q;
      fault_d = cfg_we & ~priv;
      coll_d  = 1'b0;
      if (take) begin
         psw_d  = new_word;
         coll_d = (op != OP_IDLE);
      end else begin
         unique case (op)
            OP_LOAD: begin
               if (priv) psw_d = cmd_word;
               else      fault_d = 1'b1;
            end
            OP_SETCC: psw_d[CC_LSB +: CC_W] = cmd_cc;
            OP_RETURN: begin
               if (priv) psw_d = old_word;
               else      fault_d = 1'b1;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         psw_q   <= PSW_RST;
         fault_q <= 1'b0;
         coll_q  <= 1'b0;
         taken_q <= 1'b0;
         tcls_q  <= '0;
      end else begin
         psw_q   <= psw_d;
         fault_q <= fault_d;
         coll_q  <= coll_d;
         taken_q <= take;
         if (take) tcls_q <= take_cls;
      end
   end

   psw_addr_gen #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) agen_i (
      .clk   (clk),
      .rst_n (rst_n),
      .amode (psw_q[AMODE_BIT]),
      .iaddr (psw_q[ADDR_W-1:0]),
      .eff   (eff_addr)
   );

   assign psw_word    = psw_q;
   assign irq_mask    = psw_q[WORD_W-1:MASK_LSB];
   assign supv        = priv;
   assign cc          = psw_q[CC_LSB +: CC_W];
   assign amode       = psw_q[AMODE_BIT];
   assign iaddr       = psw_q[ADDR_W-1:0];
   assign irq_taken   = taken_q;
   assign irq_cls     = tcls_q;
   assign priv_fault  = fault_q;
   assign cmd_collide = coll_q;

   AST_LOAD_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
      (!take && op == OP_LOAD && priv) |=> (psw_q == $past(cmd_word))); // R2
   AST_PROBLEM_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
      (!take && (op == OP_LOAD || op == OP_RETURN) && !priv)
         |=> (priv_fault && $stable(psw_q))); // R3
   AST_CC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (!take && op == OP_SETCC)
         |=> (((psw_q ^ $past(psw_q)) & ~CC_FIELD) == '0)); // R4
   AST_MASKED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_req & irq_mask) == '0) |=> !irq_taken); // R5
   AST_SWAP_LOADS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (irq_taken && psw_q == $past(new_word))); // R7
   AST_RETURN_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
      (!take && op == OP_RETURN && priv) |=> (psw_q == $past(old_word))); // R8
   AST_COLLIDE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (take && op != OP_IDLE) |=> (cmd_collide && irq_taken)); // R9
   AST_NO_STRAY_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> !cmd_collide); // R9
endmodule

// File: tb/psw_swap_unit_tb.sv
`timescale 1ns/1ps
module psw_swap_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cmd_op = '0;
   logic [63:0] cmd_word = '0;
   logic [1:0]  cmd_cc = '0;
   logic [1:0]  cmd_cls = '0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_cls = '0;
   logic [63:0] cfg_word = '0;
   logic [3:0]  irq_req = '0;
   logic [63:0] psw_word;
   logic [3:0]  irq_mask;
   logic        supv, amode, irq_taken, priv_fault, cmd_collide;
   logic [1:0]  cc, irq_cls;
   logic [31:0] iaddr, eff_addr;

   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;

   psw_swap_unit dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_word(cmd_word),
      .cmd_cc(cmd_cc), .cmd_cls(cmd_cls), .cfg_we(cfg_we), .cfg_cls(cfg_cls),
      .cfg_word(cfg_word), .irq_req(irq_req), .psw_word(psw_word),
      .irq_mask(irq_mask), .supv(supv), .cc(cc), .amode(amode), .iaddr(iaddr),
      .eff_addr(eff_addr), .irq_taken(irq_taken), .irq_cls(irq_cls),
      .priv_fault(priv_fault), .cmd_collide(cmd_collide)
   );

   typedef struct packed {
      logic [1:0]  op;
      logic [63:0] word;
      logic [1:0]  cc;
      logic [3:0]  irq;
      logic [63:0] exp;
      logic        fault;
      logic [7:0]  req;
   } vec_t;

   localparam logic [63:0] W_A = 64'hF800_0000_0012_3456;
   localparam logic [63:0] W_B = 64'h0100_0000_8765_4321;

   localparam vec_t VECS [7] = '{
      '{2'd1, W_A,   2'd0, 4'h0, W_A,                   1'b0, 8'd2},
      '{2'd2, 64'h0, 2'd3, 4'h0, 64'hFE00_0000_0012_3456, 1'b0, 8'd4},
      '{2'd0, 64'h0, 2'd0, 4'h0, 64'hFE00_0000_0012_3456, 1'b0, 8'd4},
      '{2'd1, W_B,   2'd0, 4'h0, W_B,                   1'b0, 8'd2},
      '{2'd1, W_A,   2'd0, 4'h0, W_B,                   1'b1, 8'd3},
      '{2'd2, 64'h0, 2'd2, 4'h0, 64'h0500_0000_8765_4321, 1'b0, 8'd4},
      '{2'd0, 64'h0, 2'd0, 4'hF, 64'h0500_0000_8765_4321, 1'b0, 8'd5}
   };

   localparam logic [63:0] N0 = 64'h3800_0000_0000_1000;
   localparam logic [63:0] N1 = 64'h0800_0000_0000_2000;
   localparam logic [63:0] N2 = 64'h0800_0000_0000_3000;
   localparam logic [63:0] N3 = 64'h0800_0000_0000_4000;
   localparam logic [63:0] P  = 64'hF000_0000_0000_0500;
   localparam logic [63:0] P2 = 64'h5000_0000_0000_0600;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic apply(input logic [1:0] op, input logic [63:0] w, input logic [1:0] c,
                        input logic [1:0] cls, input logic [3:0] irq);
      cmd_op = op; cmd_word = w; cmd_cc = c; cmd_cls = cls; irq_req = irq;
      cfg_we = 1'b0;
      @(negedge clk);
   endtask

   task automatic cfgw(input logic [1:0] cls, input logic [63:0] w);
      cmd_op = 2'd0; irq_req = '0; cfg_we = 1'b1; cfg_cls = cls; cfg_word = w;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; cmd_op = '0; irq_req = '0; cfg_we = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
   end

   initial begin
      do_reset();
      chk("R1 word", psw_word, 64'h0800_0000_0000_0000);
      chk("R1 pulses", {61'd0, irq_taken, priv_fault, cmd_collide}, 64'd0);

      for (int i = 0; i < 7; i++) begin
         apply(VECS[i].op, VECS[i].word, VECS[i].cc, 2'd0, VECS[i].irq);
         chk($sformatf("R%0d vec%0d word", VECS[i].req, i), psw_word, VECS[i].exp);
         chk($sformatf("R%0d vec%0d fault", VECS[i].req, i), {63'd0, priv_fault},
             {63'd0, VECS[i].fault});
      end
      chk("R5 masked no take", {63'd0, irq_taken}, 64'd0);
      chk("R10 wide eff", {32'd0, eff_addr}, 64'h0765_4321);

      do_reset();
      chk("R1 word after reset", psw_word, 64'h0800_0000_0000_0000);
      apply(2'd1, 64'h0800_0000_FFFF_FFFF, 2'd0, 2'd0, 4'h0);
      chk("R10 narrow eff", {32'd0, eff_addr}, 64'h00FF_FFFF);
      apply(2'd1, 64'h0900_0000_FFFF_FFFF, 2'd0, 2'd0, 4'h0);
      chk("R10 wide eff", {32'd0, eff_addr}, 64'h7FFF_FFFF);

      cfgw(2'd0, N0);
      chk("R11 no fault", {63'd0, priv_fault}, 64'd0);
      cfgw(2'd1, N1);
      cfgw(2'd2, N2);
      cfgw(2'd3, N3);

      apply(2'd1, P, 2'd0, 2'd0, 4'h0);
      chk("R2 load P", psw_word, P);
      apply(2'd0, 64'd0, 2'd0, 2'd0, 4'b0110);
      chk("R7 swap new", psw_word, N1);
      chk("R6 lowest class", {62'd0, irq_cls}, 64'd1);
      chk("R7 taken pulse", {63'd0, irq_taken}, 64'd1);
      apply(2'd3, 64'd0, 2'd0, 2'd1, 4'h0);
      chk("R8 return", psw_word, P);
      chk("R7 pulse ends", {63'd0, irq_taken}, 64'd0);

      apply(2'd2, 64'd0, 2'd3, 2'd0, 4'b1000);
      chk("R9 swap wins", psw_word, N3);
      chk("R9 collide", {62'd0, cmd_collide, irq_taken}, 64'd3);
      chk("R9 class", {62'd0, irq_cls}, 64'd3);
      apply(2'd3, 64'd0, 2'd0, 2'd3, 4'h0);
      chk("R9 dropped update", psw_word, P);
      chk("R9 collide ends", {63'd0, cmd_collide}, 64'd0);

      apply(2'd0, 64'd0, 2'd0, 2'd0, 4'b0001);
      chk("R7 class0", psw_word, N0);
      apply(2'd1, P2, 2'd0, 2'd0, 4'h0);
      chk("R2 load P2", psw_word, P2);
      apply(2'd0, 64'd0, 2'd0, 2'd0, 4'b1010);
      chk("R5 masked word", psw_word, P2);
      chk("R5 masked taken", {63'd0, irq_taken}, 64'd0);
      apply(2'd0, 64'd0, 2'd0, 2'd0, 4'b1100);
      chk("R5 enabled class2", psw_word, N2);
      chk("R6 class2", {62'd0, irq_cls}, 64'd2);
      apply(2'd3, 64'd0, 2'd0, 2'd2, 4'h0);
      chk("R8 return P2", psw_word, P2);

      cfgw(2'd0, 64'hDEAD_BEEF_0000_0000);
      chk("R11 refused fault", {63'd0, priv_fault}, 64'd1);
      apply(2'd0, 64'd0, 2'd0, 2'd0, 4'b0001);
      chk("R11 slot kept", psw_word, N0);
      apply(2'd1, P2, 2'd0, 2'd0, 4'h0);
      chk("R2 reload P2", psw_word, P2);
      apply(2'd3, 64'd0, 2'd0, 2'd0, 4'h0);
      chk("R3 return refused", psw_word, P2);
      chk("R3 fault", {63'd0, priv_fault}, 64'd1);
      apply(2'd0, 64'd0, 2'd0, 2'd0, 4'h0);
      chk("R3 single pulse", {63'd0, priv_fault}, 64'd0);

      summary();
      $finish;
   end
endmodule